// File: doc/BRIEF.md
# Power-Down and Software-Reset Controller

This block is the global control section of a peripheral chip. A small register bank, reached through a simple write/read port, decides whether the digital core is powered down. The decision comes either from an external power-down pin or from a software bit, and a select bit in the same register chooses which of the two is in charge. When the core is powered down, its clock is gated off so that its state freezes. The register bank keeps its contents and the register port keeps working.

Writing the reset-start bit launches a self-clearing reset sequence that lasts a fixed, parameterised number of cycles. The sequence returns every register field that has a defined default to that default. It leaves a scratch field, which has no defined reset value, untouched. The write that launches the sequence gets no acknowledge, and writes that arrive while the sequence runs are dropped without an acknowledge. A second register gives each of three converter channels its own power-down output.

Register map: control register at address 0x20 and converter register at address 0x21. In the control register, bit 0 is the power-down source select, bit 1 is the software power-down, bit 2 is the reset start, bit 3 reads 0, and bits 7:4 are scratch. In the converter register, bit n powers down channel n for n = 0..2, and bits 7:3 read 0.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: While `rst_n` is low on a clock edge, the control bits 3:0, the converter register, `conv_pd`, `busy` and `reg_ack` all return to 0.
- R2: With control bit 0 = 0, `core_clk_en` equals the inverse of `pd_pin`, and control bit 1 has no effect on it.
- R3: With control bit 0 = 1, `core_clk_en` equals the inverse of control bit 1, and `pd_pin` has no effect on it. Writing bit 1 back to 0 restores the clock.
- R4: `core_clk_en` changes only while `clk` is low, and `core_clk` is `clk` gated by `core_clk_en`.
- R5: While the core is powered down, register writes are still acknowledged and stored, and reads still return the stored values.
- R6: A write to an unmapped address is acknowledged and changes no readable register or output.
- R7: A write with control bit 2 = 1 raises `busy` for exactly `RST_CYCLES` cycles. It returns control bits 3:0 and the converter register to 0, so bit 2 always reads back as 0.
- R8: The write that starts the reset is not acknowledged. Writes issued while `busy` is high are neither acknowledged nor stored.
- R9: Scratch bits 7:4 of the control register keep their last written value through both the software reset and the `rst_n` reset.
- R10: `conv_pd[n]` follows bit n of the converter register, and it changes only on a write or a reset.
- R11: Every accepted write raises `reg_ack` for one cycle, starting at the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| pd_pin | input | 1 | External power-down request, active high |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| reg_ack | output | 1 | Write acknowledge, one cycle |
| busy | output | 1 | High while the software reset sequence runs |
| core_clk_en | output | 1 | Latched core clock enable |
| core_clk | output | 1 | Gated clock for the digital core |
| conv_pd | output | 3 | Per-channel converter power-down |

## Verification
Register contents, `reg_ack`, `busy` and `conv_pd` change at the clock edge that samples a write. The bench therefore drives each write just after a falling edge and samples these results after the next falling edge. Read data is combinational, so it is sampled a moment after the address is set. `core_clk_en` follows the pin during the low phase at once, but a register write moves it only at the falling edge after the write edge. The bench samples it a short delay after that falling edge, and it counts the `busy` length in whole cycles between falling edges.

// File: rtl/pwr_rst_pkg.sv
// Package: shared register map and field positions of the power-down and
// software-reset controller. Assumes 8-bit register addresses.
package pwr_rst_pkg;
    localparam logic [7:0] CTRL_ADDR    = 8'h20;
    localparam logic [7:0] CONV_ADDR    = 8'h21;
    localparam int         SEL_SW_BIT   = 0;
    localparam int         SW_PD_BIT    = 1;
    localparam int         RST_BIT      = 2;
    localparam int         SCRATCH_LSB  = 4;
endpackage

// File: rtl/pwr_rst_regs.sv
// Module: register bank with write decode and acknowledge generation.
// Assumes one-cycle write strobes. Writes are dropped while the reset
// sequence runs. Scratch bits carry no reset on purpose.
module pwr_rst_regs
    import pwr_rst_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_CONV = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                wr,
    input  logic                busy,
    output logic [DATA_W-1:0]   rdata,
    output logic                ack,
    output logic                sel_sw,
    output logic                sw_pd,
    output logic [NUM_CONV-1:0] conv_bits,
    output logic                rst_start
);
    localparam int SCR_W = DATA_W - SCRATCH_LSB;

    logic             accept;
    logic             hit_ctrl;
    logic             hit_conv;
    logic [SCR_W-1:0] scratch;

    // Purpose: qualify a write and detect the reset-start request.
    always_comb begin
        accept    = wr && !busy;
        hit_ctrl  = (addr == ADDR_W'(CTRL_ADDR));
        hit_conv  = (addr == ADDR_W'(CONV_ADDR));
        rst_start = accept && hit_ctrl && wdata[RST_BIT];
    end

    // Purpose: control fields with defaults, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_start) begin
            sel_sw <= 1'b0;
            sw_pd  <= 1'b0;
        end else if (accept && hit_ctrl) begin
            sel_sw <= wdata[SEL_SW_BIT];
            sw_pd  <= wdata[SW_PD_BIT];
        end
    end

    // Purpose: scratch field without reset value, kept through resets.
    always_ff @(posedge clk) begin
        if (accept && hit_ctrl)
            scratch <= wdata[DATA_W-1:SCRATCH_LSB];
    end

    // Purpose: converter power-down field, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_start)
            conv_bits <= '0;
        else if (accept && hit_conv)
            conv_bits <= wdata[NUM_CONV-1:0];
    end

    // Purpose: one-cycle acknowledge, withheld for the reset-start write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack <= 1'b0;
        else
            ack <= accept && !rst_start;
    end

    // Purpose: combinational read-back, reset bit always reads zero.
    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[SEL_SW_BIT]               = sel_sw;
            rdata[SW_PD_BIT]                = sw_pd;
            rdata[DATA_W-1:SCRATCH_LSB]     = scratch;
        end else if (hit_conv) begin
            rdata[NUM_CONV-1:0]             = conv_bits;
        end
    end
endmodule

// File: rtl/pwr_rst_seq.sv
// Module: fixed-length reset sequencer. Assumes RST_CYCLES >= 1.
// busy stays high for exactly RST_CYCLES cycles after a start.
module pwr_rst_seq #(
    parameter int RST_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: load the down-counter on start and drop busy at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= LOAD;
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/pwr_rst_clkgate.sv
// Module: glitch-free clock gate. The enable is captured by a latch that
// is transparent only while clk is low, so the gated clock never gets
// runt pulses.
module pwr_rst_clkgate (
    input  logic clk,
    input  logic en_req,
    output logic en_lat,
    output logic gclk
);
    // Purpose: low-phase transparent enable latch.
    always_latch begin
        if (!clk)
            en_lat = en_req;
    end

    // Purpose: gate the clock with the held enable.
    assign gclk = clk & en_lat;
endmodule

// File: rtl/pwr_rst_ctrl.sv
// Module: top of the power-down and software-reset controller. Picks the
// power-down source, gates the core clock, runs the reset sequence and
// drives per-channel converter power-down outputs.
module pwr_rst_ctrl #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int NUM_CONV   = 3,
    parameter int RST_CYCLES = 100000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pd_pin,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_wr,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                reg_ack,
    output logic                busy,
    output logic                core_clk_en,
    output logic                core_clk,
    output logic [NUM_CONV-1:0] conv_pd
);
    logic                sel_sw;
    logic                sw_pd;
    logic                rst_start;
    logic                pd_active;
    logic [NUM_CONV-1:0] conv_bits;

    pwr_rst_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_CONV(NUM_CONV)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .wr       (reg_wr),
        .busy     (busy),
        .rdata    (reg_rdata),
        .ack      (reg_ack),
        .sel_sw   (sel_sw),
        .sw_pd    (sw_pd),
        .conv_bits(conv_bits),
        .rst_start(rst_start)
    );

    pwr_rst_seq #(
        .RST_CYCLES(RST_CYCLES)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(rst_start),
        .busy (busy)
    );

    // Purpose: select which source owns the power-down decision.
    always_comb begin
        pd_active = sel_sw ? sw_pd : pd_pin;
    end

    pwr_rst_clkgate u_gate (
        .clk   (clk),
        .en_req(!pd_active),
        .en_lat(core_clk_en),
        .gclk  (core_clk)
    );

    // Purpose: one power-down output per converter channel.
    for (genvar i = 0; i < NUM_CONV; i++) begin : g_conv
        assign conv_pd[i] = conv_bits[i];
    end
endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
// Module: assertion checker for pwr_rst_ctrl, attached by bind below.
module pwr_rst_ctrl_chk #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int NUM_CONV   = 3,
    parameter int RST_CYCLES = 100000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pd_pin,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                reg_wr,
    input logic                reg_ack,
    input logic                busy,
    input logic                core_clk_en,
    input logic [NUM_CONV-1:0] conv_pd,
    input logic                sel_sw
);
    logic trig;
    logic en_at_rise;
    int   busy_len;

    assign trig = reg_wr && !busy && (reg_addr == ADDR_W'(8'h20)) && reg_wdata[2];

    // Purpose: capture the enable at each rising edge.
    always_ff @(posedge clk) en_at_rise <= core_clk_en;

    // Purpose: count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_len <= 0;
        else if (busy)
            busy_len <= busy_len + 1;
        else
            busy_len <= 0;
    end

    assert_en_stable_high_R4: assert property (@(negedge clk) disable iff (!rst_n)
        core_clk_en == en_at_rise);

    assert_pin_rules_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_sw |-> core_clk_en == !pd_pin);

    assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_len < RST_CYCLES);

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == RST_CYCLES);

    assert_trigger_noack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (!reg_ack && busy));

    assert_busy_write_noack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> !reg_ack);

    assert_write_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy && !trig) |=> reg_ack);

    assert_conv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(conv_pd));
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_CONV  (NUM_CONV),
    .RST_CYCLES(RST_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_pin     (pd_pin),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_wr     (reg_wr),
    .reg_ack    (reg_ack),
    .busy       (busy),
    .core_clk_en(core_clk_en),
    .conv_pd    (conv_pd),
    .sel_sw     (sel_sw)
);

// File: tb/pwr_rst_ctrl_test.sv
// Bench: sweeps power-down source, pin and software bit combinations,
// converter patterns, unmapped addresses and both reset paths.
module pwr_rst_ctrl_test;
    localparam int RSTC = 8;
    localparam logic [7:0] A_CTRL = 8'h20;
    localparam logic [7:0] A_CONV = 8'h21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_pin = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_rdata;
    logic       reg_ack;
    logic       busy;
    logic       core_clk_en;
    logic       core_clk;
    logic [2:0] conv_pd;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cycles = 0;
    logic last_ack;

    pwr_rst_ctrl #(.RST_CYCLES(RSTC)) uut (
        .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rdata(reg_rdata), .reg_ack(reg_ack), .busy(busy),
        .core_clk_en(core_clk_en), .core_clk(core_clk), .conv_pd(conv_pd)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write, then sample one falling edge after the write edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #2;
        last_ack = reg_ack;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pin_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
    endtask

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        rd(A_CTRL, d); chk("R1 ctrl", int'(d & 8'h0F), 0);
        rd(A_CONV, d); chk("R1 conv", int'(d), 0);
        chk("R1 conv_pd", int'(conv_pd), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ack", int'(reg_ack), 0);

        // R2 R3 R5 R11: sweep source select, software bit and pin
        for (int sel = 0; sel < 2; sel++) begin
            for (int sw = 0; sw < 2; sw++) begin
                for (int pin = 0; pin < 2; pin++) begin
                    pd_pin = pin[0];
                    wr(A_CTRL, {4'h6, 2'b00, sw[0], sel[0]});
                    chk("R11 ack", int'(last_ack), 1);
                    chk(sel ? "R3 enable" : "R2 enable", int'(core_clk_en),
                        sel ? int'(sw == 0) : int'(pin == 0));
                    rd(A_CTRL, d);
                    chk("R5 readback", int'(d), int'({4'h6, 2'b00, sw[0], sel[0]}));
                end
            end
        end
        // R3 release by writing the software bit back to 0
        pd_pin = 1'b1;
        wr(A_CTRL, 8'h03);
        chk("R3 down", int'(core_clk_en), 0);
        wr(A_CTRL, 8'h01);
        chk("R3 released", int'(core_clk_en), 1);
        pd_pin = 1'b0;

        // R10 R5: all converter patterns, written while powered down
        wr(A_CTRL, 8'h03);
        for (int p = 0; p < 8; p++) begin
            wr(A_CONV, 8'(p) | 8'hF8);
            chk("R5 ack while down", int'(last_ack), 1);
            chk("R10 conv_pd", int'(conv_pd), p);
            rd(A_CONV, d);
            chk("R10 readback", int'(d), p);
        end

        // R6: unmapped writes acknowledged, no effect
        wr(A_CTRL, 8'h90);
        wr(A_CONV, 8'h05);
        for (int a = 0; a < 256; a += 17) begin
            if (8'(a) != A_CTRL && 8'(a) != A_CONV) begin
                wr(8'(a), 8'hFF);
                chk("R6 ack", int'(last_ack), 1);
                chk("R6 conv_pd", int'(conv_pd), 5);
                chk("R6 enable", int'(core_clk_en), 1);
                rd(A_CTRL, d); chk("R6 ctrl", int'(d), 'h90);
                rd(A_CONV, d); chk("R6 conv", int'(d), 5);
            end
        end

        // R7 R8 R9: software reset from powered-down state
        wr(A_CTRL, 8'hA3);
        wr(A_CONV, 8'h07);
        chk("R3 down before reset", int'(core_clk_en), 0);
        wr(A_CTRL, 8'hA4);
        chk("R8 trigger no ack", int'(last_ack), 0);
        chk("R7 busy", int'(busy), 1);
        chk("R7 conv cleared", int'(conv_pd), 0);
        n = 1;
        while (busy && n < 100) begin
            @(negedge clk); #2;
            if (busy) n++;
        end
        chk("R7 busy length", n, RSTC);
        rd(A_CTRL, d); chk("R7 R9 ctrl after soft reset", int'(d), 'hA0);
        chk("R7 enable restored", int'(core_clk_en), 1);

        // R8: writes during busy neither acknowledged nor stored
        wr(A_CTRL, 8'h34);
        wr(A_CONV, 8'h06);
        chk("R8 busy write no ack", int'(last_ack), 0);
        chk("R8 busy write dropped", int'(conv_pd), 0);
        wr(A_CTRL, 8'h03);
        chk("R8 dropped ctrl", int'(core_clk_en), 1);
        repeat (RSTC) @(negedge clk);
        #2;
        chk("R7 idle", int'(busy), 0);
        rd(A_CTRL, d); chk("R8 ctrl unchanged", int'(d), 'h30);

        // R1 R9: pin reset clears defined bits, keeps scratch
        wr(A_CTRL, 8'h53);
        wr(A_CONV, 8'h03);
        chk("R3 down before pin reset", int'(core_clk_en), 0);
        pin_reset();
        rd(A_CTRL, d); chk("R9 scratch kept", int'(d), 'h50);
        chk("R1 conv_pd after pin reset", int'(conv_pd), 0);
        chk("R1 enable after pin reset", int'(core_clk_en), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule